// File: doc/BRIEF.md
# Back-Channel GPIO Frame Sampler

This block carries a handful of general-purpose signals over a slow serial back channel. The bit clock drives a local frame counter. The counter raises a one-cycle frame strobe once per frame of `FRAME_BITS` bit clocks. At each strobe, every outgoing GPIO slot is sampled once. The sampled vector is held as the GPIO field of the outgoing frame, together with a check bit, until the next strobe. Each slot takes its value from one of four sources: its own pin, an internal frame-sync generator, an external frame-sync input, or a constant zero. This lets several remote sensors be synchronised through one shared timing edge.

On the receive side, a frame arrives as a valid strobe, a GPIO field and a check bit. The field is copied onto the output pins only when the check bit is correct. Otherwise the outputs keep their previous value.

A small configuration register holds three settings for each pin: an input-disable bit, a pulldown-disable bit and a source select. A status vector reports the live level of every pin. An input that is disabled reads as zero in both the status vector and the sampler. The sampling rate is one frame. For this reason the transfer is only reliable for inputs that toggle at less than a quarter of the frame rate.

Top module: `bc_gpio_bridge`

## Requirements
- R1: `frameStrobe` is high for exactly one cycle in every `FRAME_BITS` cycles. Its first pulse falls in cycle `FRAME_BITS-1` after reset is released.
- R2: `txField` changes only at the clock edge that ends a strobe cycle, and then holds until the next strobe. A configuration write made in a strobe cycle does not affect that capture; it applies from the next capture.
- R3: Source select `2'b00` places `pinIn[i]` into slot i. The select for slot i is `cfgWdata[2*NUM_GPIO+2*i +: 2]`.
- R4: Source select `2'b01` places the internal frame-sync level into the slot. For capture number k, counting from 0 after reset, this level is 1 when `k mod FS_PERIOD < FS_HIGH` and 0 otherwise.
- R5: Source select `2'b10` places `extFsync` into the slot.
- R6: Source select `2'b11` places a constant 0 into the slot.
- R7: When the input-disable bit `cfgWdata[i]` is 1, pin i reads as 0 in both `pinStatus` and the sampler.
- R8: `pinStatus` shows the level of each enabled pin one clock after that level is applied.
- R9: `pullEn[i]` is the inverse of the pulldown-disable bit `cfgWdata[NUM_GPIO+i]`. After reset every input is enabled, every pulldown is enabled and every source select is pin.
- R10: `txCheck` makes the parity of `{txField, txCheck}` even.
- R11: `gpioOut` loads `rxField` one cycle after `rxValid` is high with `{rxField, rxCheck}` of even parity. In every other case it holds its value.
- R12: After reset, `txField`, `txCheck`, `gpioOut` and `pinStatus` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Back-channel bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration register write enable |
| cfgWdata | input | 4*NUM_GPIO | Configuration word: input disables, pulldown disables, source selects |
| pinIn | input | NUM_GPIO | Pin levels from the pads |
| extFsync | input | 1 | External frame-sync input |
| rxValid | input | 1 | A received back-channel frame is present |
| rxField | input | NUM_GPIO | GPIO field of the received frame |
| rxCheck | input | 1 | Check bit of the received frame |
| frameStrobe | output | 1 | Frame boundary strobe; marks the capture cycle |
| txField | output | NUM_GPIO | GPIO field for the outgoing frame |
| txCheck | output | 1 | Check bit for the outgoing frame |
| pinStatus | output | NUM_GPIO | Live pin levels, masked by input disable |
| pullEn | output | NUM_GPIO | Pulldown enable for each pad |
| gpioOut | output | NUM_GPIO | GPIO outputs driven from received frames |

## Verification
A configuration write and a frame capture can fall in the same cycle. The capture must still use the source selection that was in force before the write. The bench provokes this case directly. In a strobe cycle it switches slot 0 from its pin to constant zero while the pin is high. It then expects a 1 in that capture and a 0 in the following one. A second concern is the timing of the internal frame-sync generator: it advances at the same edge as the capture that samples it. The bench counts strobes on its own and compares each captured slot against the pattern given by the capture index.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  typedef enum logic [1:0] {
    SRC_PIN    = 2'b00,
    SRC_FS_INT = 2'b01,
    SRC_FS_EXT = 2'b10,
    SRC_ZERO   = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic capture;   // frame boundary: sample the slots this cycle
    logic fsyncInt;  // current internal frame-sync level
    logic rxLoad;    // received frame passed its check
  } ctlStrobes_t;

endpackage

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
  import bcg_pkg::*;
#(
  parameter int FRAME_BITS = 30,
  parameter int FS_PERIOD  = 4,
  parameter int FS_HIGH    = 2,
  parameter int NUM_GPIO   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [NUM_GPIO-1:0] rxField,
  input  logic                rxCheck,
  output ctlStrobes_t         strobes
);

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam int FS_W  = $clog2(FS_PERIOD + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);
  localparam logic [FS_W-1:0]  FS_LAST  = FS_W'(FS_PERIOD - 1);
  localparam logic [FS_W-1:0]  FS_HI    = FS_W'(FS_HIGH);

  logic [BIT_W-1:0] bitCnt;
  logic [FS_W-1:0]  frameCnt;
  logic             atBoundary;

  assign atBoundary = (bitCnt == BIT_LAST);

  // bit position inside the current back-channel frame
  always_ff @(posedge clk) begin
    if (!rstN)           bitCnt <= '0;
    else if (atBoundary) bitCnt <= '0;
    else                 bitCnt <= bitCnt + 1'b1;
  end

  // frame index driving the internal frame-sync generator
  always_ff @(posedge clk) begin
    if (!rstN) frameCnt <= '0;
    else if (atBoundary) begin
      if (frameCnt == FS_LAST) frameCnt <= '0;
      else                     frameCnt <= frameCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.capture  = atBoundary;
    strobes.fsyncInt = (frameCnt < FS_HI);
    strobes.rxLoad   = rxValid & ~(^{rxField, rxCheck});
  end

endmodule

// File: rtl/bcg_datapath.sv
module bcg_datapath
  import bcg_pkg::*;
#(
  parameter int NUM_GPIO = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strobes,
  input  logic                  cfgWe,
  input  logic [4*NUM_GPIO-1:0] cfgWdata,
  input  logic [NUM_GPIO-1:0]   pinIn,
  input  logic                  extFsync,
  input  logic [NUM_GPIO-1:0]   rxField,
  output logic [NUM_GPIO-1:0]   txField,
  output logic                  txCheck,
  output logic [NUM_GPIO-1:0]   pinStatus,
  output logic [NUM_GPIO-1:0]   pullEn,
  output logic [NUM_GPIO-1:0]   gpioOut
);

  localparam int CFG_W   = 4 * NUM_GPIO;
  localparam int PD_LO   = NUM_GPIO;
  localparam int SEL_LO  = 2 * NUM_GPIO;

  logic [CFG_W-1:0]    cfgReg;
  logic [NUM_GPIO-1:0] inDis;
  logic [NUM_GPIO-1:0] pdDis;
  logic [NUM_GPIO-1:0] pinGated;
  logic [NUM_GPIO-1:0] sampleVec;

  always_ff @(posedge clk) begin
    if (!rstN)      cfgReg <= '0;
    else if (cfgWe) cfgReg <= cfgWdata;
  end

  assign inDis = cfgReg[NUM_GPIO-1:0];
  assign pdDis = cfgReg[PD_LO +: NUM_GPIO];

  for (genvar i = 0; i < NUM_GPIO; i++) begin : g_pad
    assign pinGated[i] = pinIn[i] & ~inDis[i];
    assign pullEn[i]   = ~pdDis[i];
  end

  function automatic logic pickSource(input logic [1:0] sel, input logic pin,
                                      input logic fsInt, input logic fsExt);
    case (srcSel_e'(sel))
      SRC_PIN:    return pin;
      SRC_FS_INT: return fsInt;
      SRC_FS_EXT: return fsExt;
      default:    return 1'b0;
    endcase
  endfunction

  always_comb begin
    for (int i = 0; i < NUM_GPIO; i++) begin
      sampleVec[i] = pickSource(cfgReg[SEL_LO + 2*i +: 2], pinGated[i],
                                strobes.fsyncInt, extFsync);
    end
  end

  // outgoing field: captured once per frame, held in between
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txField <= '0;
      txCheck <= 1'b0;
    end else if (strobes.capture) begin
      txField <= sampleVec;
      txCheck <= ^sampleVec;
    end
  end

  // live pin level, independent of routing
  always_ff @(posedge clk) begin
    if (!rstN) pinStatus <= '0;
    else       pinStatus <= pinGated;
  end

  // received field drives the outputs only on a clean frame
  always_ff @(posedge clk) begin
    if (!rstN)               gpioOut <= '0;
    else if (strobes.rxLoad) gpioOut <= rxField;
  end

endmodule

// File: rtl/bc_gpio_bridge.sv
module bc_gpio_bridge
  import bcg_pkg::*;
#(
  parameter int FRAME_BITS = 30,
  parameter int FS_PERIOD  = 4,
  parameter int FS_HIGH    = 2,
  parameter int NUM_GPIO   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWe,
  input  logic [4*NUM_GPIO-1:0] cfgWdata,
  input  logic [NUM_GPIO-1:0]   pinIn,
  input  logic                  extFsync,
  input  logic                  rxValid,
  input  logic [NUM_GPIO-1:0]   rxField,
  input  logic                  rxCheck,
  output logic                  frameStrobe,
  output logic [NUM_GPIO-1:0]   txField,
  output logic                  txCheck,
  output logic [NUM_GPIO-1:0]   pinStatus,
  output logic [NUM_GPIO-1:0]   pullEn,
  output logic [NUM_GPIO-1:0]   gpioOut
);

  ctlStrobes_t strobes;

  bcg_ctrl #(
    .FRAME_BITS(FRAME_BITS), .FS_PERIOD(FS_PERIOD),
    .FS_HIGH(FS_HIGH), .NUM_GPIO(NUM_GPIO)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxField(rxField),
    .rxCheck(rxCheck), .strobes(strobes)
  );

  bcg_datapath #(.NUM_GPIO(NUM_GPIO)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgWe(cfgWe),
    .cfgWdata(cfgWdata), .pinIn(pinIn), .extFsync(extFsync),
    .rxField(rxField), .txField(txField), .txCheck(txCheck),
    .pinStatus(pinStatus), .pullEn(pullEn), .gpioOut(gpioOut)
  );

  assign frameStrobe = strobes.capture;

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int FRAME_BITS = 30,
  parameter int NUM_GPIO   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameStrobe,
  input logic [NUM_GPIO-1:0] txField,
  input logic                txCheck,
  input logic                rxValid,
  input logic [NUM_GPIO-1:0] rxField,
  input logic                rxCheck,
  input logic [NUM_GPIO-1:0] gpioOut
);

  localparam int CW = $clog2(FRAME_BITS) + 1;
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [CW-1:0] sinceStrobe;
  logic          rxGood;

  always_ff @(posedge clk) begin
    if (!rstN)            sinceStrobe <= '0;
    else if (frameStrobe) sinceStrobe <= '0;
    else                  sinceStrobe <= sinceStrobe + 1'b1;
  end

  assign rxGood = rxValid && !(^{rxField, rxCheck});

  // R1: strobe exactly at the end of every frame window
  p_strobe_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameStrobe == (sinceStrobe == LAST));

  // R2: outgoing field changes only after a strobe cycle
  p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |=> $stable(txField));

  // R10: check bit keeps overall parity even
  p_tx_parity_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(^{txField, txCheck}));

  // R11: clean frame loads the outputs
  p_rx_load_r11: assert property (@(posedge clk) disable iff (!rstN)
    rxGood |=> gpioOut == $past(rxField));

  // R11: anything else holds them
  p_rx_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxGood |=> $stable(gpioOut));

endmodule

bind bc_gpio_bridge bcg_checker #(.FRAME_BITS(FRAME_BITS), .NUM_GPIO(NUM_GPIO)) u_chk (
  .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .txField(txField),
  .txCheck(txCheck), .rxValid(rxValid), .rxField(rxField),
  .rxCheck(rxCheck), .gpioOut(gpioOut)
);

// File: tb/sim_bc_gpio_bridge.sv
module sim_bc_gpio_bridge;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int FB         = 30;
  localparam int FSP        = 4;
  localparam int FSH        = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           cfgWe = 1'b0;
  logic [4*N-1:0] cfgWdata = '0;
  logic [N-1:0]   pinIn = '0;
  logic           extFsync = 1'b0;
  logic           rxValid = 1'b0;
  logic [N-1:0]   rxField = '0;
  logic           rxCheck = 1'b0;
  logic           frameStrobe;
  logic [N-1:0]   txField;
  logic           txCheck;
  logic [N-1:0]   pinStatus;
  logic [N-1:0]   pullEn;
  logic [N-1:0]   gpioOut;

  int checks = 0;
  int fails  = 0;
  int capCount = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bc_gpio_bridge #(.FRAME_BITS(FB), .FS_PERIOD(FSP), .FS_HIGH(FSH), .NUM_GPIO(N)) u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .pinIn(pinIn),
    .extFsync(extFsync), .rxValid(rxValid), .rxField(rxField), .rxCheck(rxCheck),
    .frameStrobe(frameStrobe), .txField(txField), .txCheck(txCheck),
    .pinStatus(pinStatus), .pullEn(pullEn), .gpioOut(gpioOut)
  );

  always @(posedge clk) if (rstN && frameStrobe) capCount <= capCount + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4*N-1:0] cfgWord(input logic [N-1:0] inD, input logic [N-1:0] pdD,
                                             input logic [2*N-1:0] sel);
    return {sel, pdD, inD};
  endfunction

  task automatic writeCfg(input logic [4*N-1:0] w);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = w;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // leaves the bench at the negedge inside a strobe cycle
  task automatic waitStrobe();
    do @(negedge clk); while (!frameStrobe);
  endtask

  task automatic captureWith(input logic [N-1:0] pins, input logic ext, output logic [N-1:0] got);
    waitStrobe();
    pinIn = pins; extFsync = ext;
    @(negedge clk);
    got = txField;
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R12 txField", txField, 0);
    check("R12 txCheck", txCheck, 0);
    check("R12 gpioOut", gpioOut, 0);
    check("R12 pinStatus", pinStatus, 0);
    check("R9 pullEn reset", pullEn, {N{1'b1}});
  endtask

  task automatic testStrobe();
    int cyc = 0;
    int first = -1;
    int second = -1;
    int width = 0;
    // reset released just before this task; cycle 0 is the first edge after release
    while (second < 0 && cyc < 3*FB) begin
      @(negedge clk);
      if (frameStrobe) begin
        width++;
        if (first < 0) first = cyc; else second = cyc;
      end
      cyc++;
    end
    check("R1 first strobe", first, FB-1);
    check("R1 spacing", second - first, FB);
    check("R1 pulse count", width, 2);
  endtask

  task automatic testPinSource();
    logic [N-1:0] got;
    captureWith(4'b1010, 1'b0, got);
    check("R3 pins 1010", got, 4'b1010);
    check("R10 parity", txCheck, 1'b0);
    captureWith(4'b0111, 1'b0, got);
    check("R3 pins 0111", got, 4'b0111);
    check("R10 parity odd", txCheck, 1'b1);
    // R2: change pins mid-frame, field must hold
    repeat (5) @(negedge clk);
    pinIn = 4'b0000;
    repeat (5) @(negedge clk);
    check("R2 hold mid-frame", txField, 4'b0111);
  endtask

  task automatic testFsyncSources();
    logic [N-1:0] got;
    int k;
    // slot0 pin, slot1 internal fs, slot2 external fs, slot3 zero
    writeCfg(cfgWord('0, '0, {2'b11, 2'b10, 2'b01, 2'b00}));
    for (int f = 0; f < FSP + 1; f++) begin
      waitStrobe();
      k = capCount;
      pinIn = 4'b1111; extFsync = f[0];
      @(negedge clk);
      got = txField;
      check("R4 internal fsync", got[1], ((k % FSP) < FSH) ? 1'b1 : 1'b0);
      check("R5 external fsync", got[2], f[0]);
      check("R6 constant zero", got[3], 1'b0);
      check("R3 pin slot0", got[0], 1'b1);
    end
  endtask

  task automatic testDisable();
    logic [N-1:0] got;
    writeCfg(cfgWord(4'b0101, 4'b0011, '0));
    check("R9 pullEn", pullEn, 4'b1100);
    @(negedge clk);
    pinIn = 4'b1111;
    @(negedge clk);
    check("R7 status masked", pinStatus, 4'b1010);
    captureWith(4'b1111, 1'b0, got);
    check("R7 sampler masked", got, 4'b1010);
    writeCfg('0);
    @(negedge clk);
    pinIn = 4'b0110;
    @(negedge clk);
    check("R8 status live", pinStatus, 4'b0110);
    pinIn = 4'b1001;
    @(negedge clk);
    check("R8 status follows", pinStatus, 4'b1001);
  endtask

  task automatic testCfgAtStrobe();
    writeCfg('0);
    waitStrobe();
    pinIn = 4'b0001;
    cfgWe = 1'b1;
    cfgWdata = cfgWord('0, '0, {6'b000000, 2'b11});
    @(negedge clk);
    cfgWe = 1'b0;
    check("R2 capture uses old cfg", txField[0], 1'b1);
    waitStrobe();
    @(negedge clk);
    check("R2 new cfg next capture", txField[0], 1'b0);
    writeCfg('0);
  endtask

  task automatic testRx();
    @(negedge clk);
    rxValid = 1'b1; rxField = 4'b1011; rxCheck = ^4'b1011;
    @(negedge clk);
    rxValid = 1'b0;
    check("R11 clean load", gpioOut, 4'b1011);
    rxValid = 1'b1; rxField = 4'b0100; rxCheck = ~(^4'b0100);
    @(negedge clk);
    rxValid = 1'b0;
    check("R11 bad check holds", gpioOut, 4'b1011);
    rxField = 4'b0110; rxCheck = ^4'b0110;
    @(negedge clk);
    check("R11 no valid holds", gpioOut, 4'b1011);
    rxValid = 1'b1; rxField = 4'b0110; rxCheck = ^4'b0110;
    @(negedge clk);
    rxValid = 1'b0;
    check("R11 second load", gpioOut, 4'b0110);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(posedge clk);
    #1 rstN = 1'b1;
    testStrobe();
    testPinSource();
    testFsyncSources();
    testDisable();
    testCfgAtStrobe();
    testRx();
    finishRun();
  end

endmodule